// File: doc/BRIEF.md
# Register Scoreboard Hazard Interlock

This block sits at the issue stage of a pipeline that dispatches into several functional units. It holds one pending-write tag bit per architectural register, marking that register as hazard-prone while an instruction that will write it is still in flight. It also remembers, for every reserved unit, which registers that unit's instruction still has to read.

An instruction arrives with a target unit, an optional destination register and up to two optional source registers. The block checks it against all in-flight work. A source that is waiting for a write is a read-after-write hazard. A destination that is already waiting for a write is a write-after-write hazard. A destination that an in-flight instruction has yet to read is a write-after-read hazard. A unit that is busy also blocks issue. If none of these apply, the instruction issues at once. The block then tags its destination and reserves its unit.

When a unit reports completion, the block releases the destination tag, the pending reads and the unit reservation held by that unit's instruction. A release takes effect in the same cycle, so an instruction that was waiting on it issues in that cycle.

Top module: `sb_interlock`

## Requirements
- R1: After reset no register is tagged and no unit is reserved, so the first valid instruction to an idle unit issues (`issue_o`=1, `stall_o`=0).
- R2: A valid, nonzero source register whose pending-write tag is set stalls issue with `stall_o`=1 (read-after-write).
- R3: A nonzero destination whose pending-write tag is set stalls issue with `stall_o`=2 (write-after-write).
- R4: A nonzero destination equal to a valid source of an instruction held in any reserved unit stalls issue with `stall_o`=3 (write-after-read).
- R5: When the target unit is busy, either through `unit_busy_i[in_unit_i]` or through the block's own reservation, issue stalls with `stall_o`=4.
- R6: When several conditions hold, `stall_o` reports the highest-priority one, in the order RAW, WAW, WAR, unit. `issue_o` is 1 exactly when `in_valid_i` is 1 and no condition holds. With `in_valid_i`=0, both `issue_o` and `stall_o` are 0.
- R7: Register 0 never gets a tag and never causes a hazard, whether as source or destination. An instruction with `in_dst_v_i`=0 sets no tag.
- R8: On issue, the nonzero destination is tagged and the target unit is reserved from the next cycle on.
- R9: `done_valid_i` for a reserved unit clears that unit's destination tag, its pending reads and its reservation. An instruction checked in the same cycle already sees these as released.
- R10: `done_valid_i` for a unit that is not reserved has no effect on any tag or reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | An instruction is presented for issue |
| in_unit_i | input | UNIT_W | Target functional unit |
| in_dst_v_i | input | 1 | Instruction writes a destination |
| in_dst_i | input | REG_W | Destination register |
| in_src0_v_i | input | 1 | First source is used |
| in_src0_i | input | REG_W | First source register |
| in_src1_v_i | input | 1 | Second source is used |
| in_src1_i | input | REG_W | Second source register |
| unit_busy_i | input | NUM_UNITS | External busy status per unit |
| done_valid_i | input | 1 | A unit has finished its instruction |
| done_unit_i | input | UNIT_W | Unit that finished |
| issue_o | output | 1 | Instruction issues this cycle |
| stall_o | output | 3 | Stall reason: 0 none, 1 RAW, 2 WAW, 3 WAR, 4 unit busy |

## Verification
The assertions assume that each input field is a known value in every cycle after reset. They also assume that a completion and an issue to the same unit in the same cycle mean "release, then reserve again". Completions for units that are not reserved are allowed and are expected to be ignored. The random stimulus draws every field in every cycle. It picks completion units at random, so some of them hit idle units. It confines register indices to a small range so that all hazard kinds, and combinations of them, occur often.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [2:0] {
        STALL_NONE = 3'd0,
        STALL_RAW  = 3'd1,
        STALL_WAW  = 3'd2,
        STALL_WAR  = 3'd3,
        STALL_UNIT = 3'd4
    } stall_e;
endpackage

// File: rtl/sb_tag_file.sv
module sb_tag_file #(
    parameter int NUM_REGS = 32,
    localparam int REG_W = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_v,
    input  logic [REG_W-1:0]    set_idx,
    input  logic                clr_v,
    input  logic [REG_W-1:0]    clr_idx,
    output logic [NUM_REGS-1:0] tag_q_o,
    output logic [NUM_REGS-1:0] tag_eff_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0] tag;
    } tag_st_t;

    tag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tag_eff_o = st_q.tag;
        if (clr_v) begin
            tag_eff_o[clr_idx] = 1'b0;
            st_d.tag[clr_idx]  = 1'b0;
        end
        if (set_v && set_idx != '0) begin
            st_d.tag[set_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tag_q_o = st_q.tag;

    a_r7_reg0_never_tagged: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.tag[0]);
endmodule

// File: rtl/sb_unit_table.sv
module sb_unit_table #(
    parameter int NUM_REGS  = 32,
    parameter int NUM_UNITS = 4,
    localparam int REG_W  = $clog2(NUM_REGS),
    localparam int UNIT_W = $clog2(NUM_UNITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_v,
    input  logic [UNIT_W-1:0]    alloc_unit,
    input  logic                 alloc_dst_v,
    input  logic [REG_W-1:0]     alloc_dst,
    input  logic                 alloc_s0_v,
    input  logic [REG_W-1:0]     alloc_s0,
    input  logic                 alloc_s1_v,
    input  logic [REG_W-1:0]     alloc_s1,
    input  logic                 rel_req,
    input  logic [UNIT_W-1:0]    rel_unit,
    output logic                 rel_fire_o,
    output logic                 rel_dst_v_o,
    output logic [REG_W-1:0]     rel_dst_o,
    output logic [NUM_UNITS-1:0] res_q_o,
    output logic [NUM_UNITS-1:0] res_eff_o,
    output logic [NUM_REGS-1:0]  rd_eff_o
);
    typedef struct packed {
        logic             busy;
        logic             dv;
        logic [REG_W-1:0] dst;
        logic             s0v;
        logic [REG_W-1:0] s0;
        logic             s1v;
        logic [REG_W-1:0] s1;
    } rec_t;

    rec_t [NUM_UNITS-1:0] tab_d, tab_q;

    always_comb begin
        tab_d       = tab_q;
        rel_fire_o  = rel_req && tab_q[rel_unit].busy;
        rel_dst_v_o = rel_fire_o && tab_q[rel_unit].dv;
        rel_dst_o   = tab_q[rel_unit].dst;
        for (int u = 0; u < NUM_UNITS; u++) begin
            res_q_o[u] = tab_q[u].busy;
        end
        res_eff_o = res_q_o;
        if (rel_fire_o) begin
            res_eff_o[rel_unit] = 1'b0;
            tab_d[rel_unit]     = '0;
        end
        rd_eff_o = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (res_eff_o[u]) begin
                if (tab_q[u].s0v) rd_eff_o[tab_q[u].s0] = 1'b1;
                if (tab_q[u].s1v) rd_eff_o[tab_q[u].s1] = 1'b1;
            end
        end
        if (alloc_v) begin
            tab_d[alloc_unit].busy = 1'b1;
            tab_d[alloc_unit].dv   = alloc_dst_v && alloc_dst != '0;
            tab_d[alloc_unit].dst  = alloc_dst;
            tab_d[alloc_unit].s0v  = alloc_s0_v && alloc_s0 != '0;
            tab_d[alloc_unit].s0   = alloc_s0;
            tab_d[alloc_unit].s1v  = alloc_s1_v && alloc_s1 != '0;
            tab_d[alloc_unit].s1   = alloc_s1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    a_r9_release_frees_unit: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_fire_o && !(alloc_v && alloc_unit == rel_unit)) |=> !res_q_o[$past(rel_unit)]);
    a_r8_alloc_reserves: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_v |=> res_q_o[$past(alloc_unit)]);
endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check
    import sb_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    parameter int NUM_UNITS = 4,
    localparam int REG_W  = $clog2(NUM_REGS),
    localparam int UNIT_W = $clog2(NUM_UNITS)
) (
    input  logic                 valid,
    input  logic [UNIT_W-1:0]    unit,
    input  logic                 dst_v,
    input  logic [REG_W-1:0]     dst,
    input  logic                 s0_v,
    input  logic [REG_W-1:0]     s0,
    input  logic                 s1_v,
    input  logic [REG_W-1:0]     s1,
    input  logic [NUM_REGS-1:0]  wr_eff,
    input  logic [NUM_REGS-1:0]  rd_eff,
    input  logic [NUM_UNITS-1:0] unit_blk,
    output logic                 issue_o,
    output stall_e               stall_o
);
    logic raw, waw, war, ubusy, dst_live;

    always_comb begin
        dst_live = dst_v && dst != '0;
        raw   = (s0_v && s0 != '0 && wr_eff[s0]) || (s1_v && s1 != '0 && wr_eff[s1]);
        waw   = dst_live && wr_eff[dst];
        war   = dst_live && rd_eff[dst];
        ubusy = unit_blk[unit];
        if (!valid)     stall_o = STALL_NONE;
        else if (raw)   stall_o = STALL_RAW;
        else if (waw)   stall_o = STALL_WAW;
        else if (war)   stall_o = STALL_WAR;
        else if (ubusy) stall_o = STALL_UNIT;
        else            stall_o = STALL_NONE;
        issue_o = valid && !raw && !waw && !war && !ubusy;
    end
endmodule

// File: rtl/sb_interlock.sv
module sb_interlock
    import sb_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    parameter int NUM_UNITS = 4,
    localparam int REG_W  = $clog2(NUM_REGS),
    localparam int UNIT_W = $clog2(NUM_UNITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid_i,
    input  logic [UNIT_W-1:0]    in_unit_i,
    input  logic                 in_dst_v_i,
    input  logic [REG_W-1:0]     in_dst_i,
    input  logic                 in_src0_v_i,
    input  logic [REG_W-1:0]     in_src0_i,
    input  logic                 in_src1_v_i,
    input  logic [REG_W-1:0]     in_src1_i,
    input  logic [NUM_UNITS-1:0] unit_busy_i,
    input  logic                 done_valid_i,
    input  logic [UNIT_W-1:0]    done_unit_i,
    output logic                 issue_o,
    output logic [2:0]           stall_o
);
    logic [NUM_REGS-1:0]  wr_tag_q, wr_eff, rd_eff;
    logic [NUM_UNITS-1:0] res_q, res_eff;
    logic                 rel_fire, rel_dst_v;
    logic [REG_W-1:0]     rel_dst;
    stall_e               stall_w;
    logic                 issue_w;

    sb_unit_table #(.NUM_REGS(NUM_REGS), .NUM_UNITS(NUM_UNITS)) u_table (
        .clk(clk), .rst_n(rst_n),
        .alloc_v(issue_w), .alloc_unit(in_unit_i),
        .alloc_dst_v(in_dst_v_i), .alloc_dst(in_dst_i),
        .alloc_s0_v(in_src0_v_i), .alloc_s0(in_src0_i),
        .alloc_s1_v(in_src1_v_i), .alloc_s1(in_src1_i),
        .rel_req(done_valid_i), .rel_unit(done_unit_i),
        .rel_fire_o(rel_fire), .rel_dst_v_o(rel_dst_v), .rel_dst_o(rel_dst),
        .res_q_o(res_q), .res_eff_o(res_eff), .rd_eff_o(rd_eff)
    );

    sb_tag_file #(.NUM_REGS(NUM_REGS)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .set_v(issue_w && in_dst_v_i), .set_idx(in_dst_i),
        .clr_v(rel_dst_v), .clr_idx(rel_dst),
        .tag_q_o(wr_tag_q), .tag_eff_o(wr_eff)
    );

    sb_hazard_check #(.NUM_REGS(NUM_REGS), .NUM_UNITS(NUM_UNITS)) u_check (
        .valid(in_valid_i), .unit(in_unit_i),
        .dst_v(in_dst_v_i), .dst(in_dst_i),
        .s0_v(in_src0_v_i), .s0(in_src0_i),
        .s1_v(in_src1_v_i), .s1(in_src1_i),
        .wr_eff(wr_eff), .rd_eff(rd_eff),
        .unit_blk(unit_busy_i | res_eff),
        .issue_o(issue_w), .stall_o(stall_w)
    );

    assign issue_o = issue_w;
    assign stall_o = stall_w;

    a_r8_dst_tagged: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o && in_dst_v_i && in_dst_i != '0) |=> wr_tag_q[$past(in_dst_i)]);
    a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && unit_busy_i[in_unit_i]) |-> !issue_o);
    a_r10_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid_i && !res_q[done_unit_i] && !issue_o) |=> (wr_tag_q == $past(wr_tag_q)));
    a_r2_tagged_src_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_src0_v_i && wr_tag_q[in_src0_i] && !done_valid_i) |-> !issue_o);
endmodule

// File: tb/sb_interlock_bench.sv
module sb_interlock_bench;
    localparam int NR = 32;
    localparam int NU = 4;
    localparam int RW = $clog2(NR);
    localparam int UW = $clog2(NU);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid, dst_v, s0_v, s1_v, done_v;
    logic [UW-1:0] unit_sel, done_u;
    logic [RW-1:0] dst, s0, s1;
    logic [NU-1:0] ubusy;
    logic issue;
    logic [2:0] stall;

    int vectors = 0;
    int errors = 0;

    bit m_wr [NR];
    bit m_res [NU];
    bit m_dv [NU];
    int m_dst [NU];
    bit m_s0v [NU];
    int m_s0 [NU];
    bit m_s1v [NU];
    int m_s1 [NU];

    always #4 clk = ~clk;

    sb_interlock #(.NUM_REGS(NR), .NUM_UNITS(NU)) u_sb_interlock (
        .clk(clk), .rst_n(rst_n),
        .in_valid_i(in_valid), .in_unit_i(unit_sel),
        .in_dst_v_i(dst_v), .in_dst_i(dst),
        .in_src0_v_i(s0_v), .in_src0_i(s0),
        .in_src1_v_i(s1_v), .in_src1_i(s1),
        .unit_busy_i(ubusy),
        .done_valid_i(done_v), .done_unit_i(done_u),
        .issue_o(issue), .stall_o(stall)
    );

    function automatic string tag_of(int code);
        case (code)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic int expect_code(output bit iss);
        bit wr [NR];
        bit rd [NR];
        bit rs [NU];
        bit raw, waw, war, ub;
        int rel;
        wr = m_wr;
        rs = m_res;
        rel = -1;
        if (done_v && m_res[done_u]) begin
            rel = int'(done_u);
            rs[rel] = 0;
            if (m_dv[rel]) wr[m_dst[rel]] = 0;
        end
        foreach (rd[i]) rd[i] = 0;
        for (int u = 0; u < NU; u++) begin
            if (rs[u]) begin
                if (m_s0v[u]) rd[m_s0[u]] = 1;
                if (m_s1v[u]) rd[m_s1[u]] = 1;
            end
        end
        raw = (s0_v && s0 != 0 && wr[s0]) || (s1_v && s1 != 0 && wr[s1]);
        waw = dst_v && dst != 0 && wr[dst];
        war = dst_v && dst != 0 && rd[dst];
        ub  = ubusy[unit_sel] || rs[unit_sel];
        iss = in_valid && !raw && !waw && !war && !ub;
        if (!in_valid) return 0;
        if (raw) return 1;
        if (waw) return 2;
        if (war) return 3;
        if (ub) return 4;
        return 0;
    endfunction

    task automatic model_update(bit iss);
        if (done_v && m_res[done_u]) begin
            m_res[done_u] = 0;
            if (m_dv[done_u]) m_wr[m_dst[done_u]] = 0;
        end
        if (iss) begin
            m_res[unit_sel] = 1;
            m_dv[unit_sel]  = dst_v && dst != 0;
            m_dst[unit_sel] = int'(dst);
            m_s0v[unit_sel] = s0_v && s0 != 0;
            m_s0[unit_sel]  = int'(s0);
            m_s1v[unit_sel] = s1_v && s1 != 0;
            m_s1[unit_sel]  = int'(s1);
            if (dst_v && dst != 0) m_wr[dst] = 1;
        end
    endtask

    task automatic check_now(string req);
        bit eiss;
        int ecode;
        string r;
        ecode = expect_code(eiss);
        r = (req == "") ? tag_of(ecode) : req;
        vectors++;
        if (issue !== eiss || stall !== 3'(ecode)) begin
            errors++;
            $display("FAIL %s: issue=%0b stall=%0d expected issue=%0b stall=%0d",
                     r, issue, stall, eiss, ecode);
        end
        model_update(eiss);
    endtask

    task automatic step(string req, bit v, int u, bit dv, int d, bit a0, int r0,
                        bit a1, int r1, bit dn, int du, logic [NU-1:0] bz);
        @(negedge clk);
        in_valid = v; unit_sel = UW'(u); dst_v = dv; dst = RW'(d);
        s0_v = a0; s0 = RW'(r0); s1_v = a1; s1 = RW'(r1);
        done_v = dn; done_u = UW'(du); ubusy = bz;
        #1;
        check_now(req);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        foreach (m_wr[i]) m_wr[i] = 0;
        for (int u = 0; u < NU; u++) begin
            m_res[u] = 0; m_dv[u] = 0; m_dst[u] = 0;
            m_s0v[u] = 0; m_s0[u] = 0; m_s1v[u] = 0; m_s1[u] = 0;
        end
        in_valid = 0; unit_sel = 0; dst_v = 0; dst = 0; s0_v = 0; s0 = 0;
        s1_v = 0; s1 = 0; done_v = 0; done_u = 0; ubusy = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // idle reset state, R6 no valid
        step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, '0);
        // R1 first instruction issues: r1 <- r2, r3 on unit 0
        step("R1", 1, 0, 1, 1, 1, 2, 1, 3, 0, 0, '0);
        // R2 read of r1 while pending
        step("R2", 1, 1, 1, 4, 1, 1, 0, 0, 0, 0, '0);
        // R3 write r1 again
        step("R3", 1, 1, 1, 1, 1, 5, 0, 0, 0, 0, '0);
        // R4 write r2, still to be read by unit 0
        step("R4", 1, 1, 1, 2, 1, 6, 0, 0, 0, 0, '0);
        // R5 unit 0 reserved
        step("R5", 1, 0, 1, 5, 1, 6, 0, 0, 0, 0, '0);
        // R5 external busy on idle unit 3
        step("R5", 1, 3, 1, 5, 1, 6, 0, 0, 0, 0, 4'b1000);
        // R6 priority: RAW beats WAW and unit busy
        step("R6", 1, 0, 1, 1, 1, 1, 0, 0, 0, 0, '0);
        // R10 completion on idle unit 2 changes nothing
        step("R10", 1, 1, 1, 4, 1, 1, 0, 0, 1, 2, '0);
        step("R10", 1, 1, 1, 4, 1, 1, 0, 0, 0, 0, '0);
        // R9 same-cycle release lets dependent issue
        step("R9", 1, 1, 1, 4, 1, 1, 0, 0, 1, 0, '0);
        // R7 writing r0 sets no tag; reading r0 is never a hazard
        step("R7", 1, 2, 1, 0, 1, 7, 0, 0, 0, 0, '0);
        step("R7", 1, 3, 1, 8, 1, 0, 1, 0, 0, 0, '0);
        // R8 tag set by issue: reading r8 now stalls
        step("R8", 1, 0, 0, 0, 1, 8, 0, 0, 0, 0, '0);
        // R7 no-destination instruction sets no tag
        step("R9", 1, 0, 0, 9, 0, 0, 0, 0, 1, 3, '0);
        step("R7", 1, 3, 1, 10, 1, 9, 0, 0, 0, 0, '0);

        for (int i = 0; i < 4000; i++) begin
            step("", ($urandom % 10) < 8, int'($urandom % NU),
                 ($urandom % 100) < 85, int'($urandom % 8),
                 ($urandom % 10) < 7, int'($urandom % 8),
                 ($urandom % 10) < 7, int'($urandom % 8),
                 ($urandom % 10) < 4, int'($urandom % NU),
                 NU'((($urandom % 10) == 0) ? ($urandom % 16) : 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule